// File: doc/BRIEF.md
# Continuous-Capable Serial Receive Master

This block is the receive half of a three-wire synchronous serial master. It generates the serial clock from the system clock, samples the serial data line once per bit and assembles each word into a receive buffer. Software sets the word length, bit order, clock polarity and data phase. A read strobe on the buffer starts a reception. The first read after power-up only starts the first word and returns nothing useful.

There are two ways to run it. In single-word mode, each buffer read starts exactly one word. In continuous mode, one read starts a stream: words follow each other with no idle bit time between them. The stream stops when software clears the continue bit, and the word being shifted at that moment is still finished. A one-cycle completion pulse marks every word written to the buffer. A sticky overrun flag records that a word was overwritten before it was read.

Top module: `serial_rx_master`

## Requirements
- R1: While `cfg_on` is 0, no word is shifted: `busy` and `rx_done` are 0 one cycle after it falls, `sclk` holds its idle level and read strobes are ignored. Dropping `cfg_on` during a word aborts that word without a completion pulse.
- R2: A read strobe starts a word only when `cfg_on`, `cfg_rx_en` and `cfg_go` are all 1 and `busy` is 0. With `cfg_rx_en` or `cfg_go` at 0, the strobe starts nothing.
- R3: With `cfg_lsb_first`=0 the first bit received lands in bit length-1 of `rx_data`. With `cfg_lsb_first`=1 it lands in bit 0. The word is right-aligned and the bits above the length are 0.
- R4: The word length is 8+`cfg_len` bits for codes 0 to MAX_BITS-8 (0 to 8 by default). Every larger code gives 8 bits.
- R5: Each bit lasts DIV system cycles. While a word is shifting, `sclk` equals `cfg_cpol` in the first DIV/2 cycles of each bit and its inverse in the rest. When idle, `sclk` rests at `cfg_cpha` XOR `cfg_cpol`. `sdi` is sampled on the system edge that ends the first half of the bit.
- R6: `busy` rises on the cycle after an accepted read and, in single-word mode, stays high for exactly length×DIV cycles.
- R7: At the end of a word, `rx_data` takes the new word and `rx_done` is high for exactly one cycle.
- R8: In single-word mode, after a word completes no further word starts until another read strobe.
- R9: In continuous mode with `cfg_on`, `cfg_rx_en` and `cfg_go` held at 1, the next word starts on the cycle the previous one ends. Completion pulses come exactly length×DIV cycles apart, and read strobes issued while `busy` is 1 do not restart the word.
- R10: Clearing `cfg_go` while a word is shifting lets that word complete, and no word follows it.
- R11: `overrun` is set when a word completes while the previous word is still unread, and the newer word replaces the buffer. `overrun` returns to 0 only when `cfg_on` is cleared or on reset.
- R12: `rx_data` changes only on a completion and keeps its value across aborted words and power-down.
- R13: After reset, `busy`, `rx_done`, `overrun` and `rx_data` are 0 and `sclk` is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_on | input | 1 | Power/enable for clock and logic |
| cfg_rx_en | input | 1 | Reception enable |
| cfg_lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| cfg_cont | input | 1 | 1 selects continuous mode |
| cfg_cpol | input | 1 | Serial clock polarity |
| cfg_cpha | input | 1 | Data phase; sets idle level with polarity |
| cfg_len | input | 4 | Word-length code |
| cfg_go | input | 1 | Serial-continue bit |
| buf_rd | input | 1 | One-cycle read strobe of the receive buffer |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock out |
| rx_data | output | MAX_BITS | Receive buffer, right-aligned |
| busy | output | 1 | Word shifting in progress |
| rx_done | output | 1 | One-cycle receive-complete pulse |
| overrun | output | 1 | Sticky unread-word-overwritten flag |

## Verification
The embedded properties watch, on every cycle, the rules that relate a few signals over one or two edges: power-down clearing `busy`, the legal causes of a rising `busy`, the single-cycle completion pulse, the stop after a completion in single-word mode or with the continue bit cleared, the rise of `overrun` only on a completion, and the holding of the buffer between completions. Other behaviour only shows up when a serial slave feeds the data line and the bench counts cycles. That covers the bit order and length mapping across polarity and phase settings, the length×DIV busy window, the seamless spacing of continuous words, and aborted or ignored starts.

// File: rtl/serial_rx_master.sv
module serial_rx_master #(
  parameter int DIV      = 4,
  parameter int MAX_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_on,
  input  logic                cfg_rx_en,
  input  logic                cfg_lsb_first,
  input  logic                cfg_cont,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic [3:0]          cfg_len,
  input  logic                cfg_go,
  input  logic                buf_rd,
  input  logic                sdi,
  output logic                sclk,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                busy,
  output logic                rx_done,
  output logic                overrun
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int LW   = $clog2(MAX_BITS + 1);

  logic [CW-1:0]       cnt;
  logic [LW-1:0]       bitcnt;
  logic [LW-1:0]       len_w;
  logic [LW-1:0]       bitpos;
  logic [MAX_BITS-1:0] shreg;
  logic                pending;

  always_comb begin
    if (int'(cfg_len) <= MAX_BITS - 8) len_w = LW'(cfg_len) + LW'(8);
    else                               len_w = LW'(8);
  end

  wire run      = cfg_on & cfg_rx_en;
  wire start    = buf_rd & run & cfg_go & ~busy;
  wire mid      = busy & (cnt == CW'(HALF - 1));
  wire last_tik = busy & (cnt == CW'(DIV - 1));
  wire last_bit = (bitcnt == len_w - LW'(1));
  wire more     = cfg_cont & cfg_go & run;

  assign bitpos = cfg_lsb_first ? bitcnt : (len_w - LW'(1) - bitcnt);
  assign sclk   = (busy ? (cnt >= CW'(HALF)) : cfg_cpha) ^ cfg_cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      bitcnt  <= '0;
      shreg   <= '0;
      rx_data <= '0;
      busy    <= 1'b0;
      rx_done <= 1'b0;
      overrun <= 1'b0;
      pending <= 1'b0;
    end else if (!cfg_on) begin
      cnt     <= '0;
      bitcnt  <= '0;
      busy    <= 1'b0;
      rx_done <= 1'b0;
      overrun <= 1'b0;
      pending <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (buf_rd) pending <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        bitcnt <= '0;
        shreg  <= '0;
      end else if (busy) begin
        cnt <= last_tik ? '0 : cnt + CW'(1);
        if (mid) shreg <= shreg | (MAX_BITS'(sdi) << bitpos);
        if (last_tik) begin
          if (last_bit) begin
            rx_data <= shreg;
            rx_done <= 1'b1;
            pending <= 1'b1;
            if (pending && !buf_rd) overrun <= 1'b1;
            bitcnt  <= '0;
            shreg   <= '0;
            busy    <= more;
          end else begin
            bitcnt <= bitcnt + LW'(1);
          end
        end
      end
    end
  end

  // R1
  power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_on |=> (!busy && !rx_done));

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(buf_rd) && $past(cfg_rx_en) && $past(cfg_go)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R8
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !$past(cfg_cont)) |-> !busy);

  // R10
  last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !$past(cfg_go)) |-> !busy);

  // R11
  overrun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> rx_done);

  // R12
  buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_data));

endmodule

// File: tb/serial_rx_master_tb_top.sv
`timescale 1ns/1ps
module serial_rx_master_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_on = 0, cfg_rx_en = 0, cfg_lsb_first = 0, cfg_cont = 0;
  logic cfg_cpol = 0, cfg_cpha = 1, cfg_go = 0, buf_rd = 0;
  logic [3:0] cfg_len = 4'd0;
  logic sdi, sclk, busy, rx_done, overrun;
  logic [15:0] rx_data;

  int total = 0;
  int bad = 0;

  logic [255:0] stream = '0;
  int idx = 0;
  assign sdi = stream[idx];

  always #2 clk = ~clk;

  serial_rx_master #(.DIV(DIV), .MAX_BITS(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_on(cfg_on), .cfg_rx_en(cfg_rx_en),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cont(cfg_cont), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_len(cfg_len), .cfg_go(cfg_go), .buf_rd(buf_rd),
    .sdi(sdi), .sclk(sclk), .rx_data(rx_data), .busy(busy),
    .rx_done(rx_done), .overrun(overrun)
  );

  // slave: present next bit just after each sampling edge
  always @(sclk) begin
    if (busy && sclk === ~cfg_cpol) begin
      #1;
      idx = idx + 1;
    end
  end

  // [31]=lsb_first [30]=cpol [29]=cpha [27:24]=len code [15:0]=data
  localparam logic [31:0] VEC [7] = '{
    32'h2000_0055, 32'hA000_00A3, 32'h4000_003C, 32'h6800_BEEF,
    32'h8400_0ABC, 32'h2F00_01C5, 32'hE100_0155
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [3:0] code);
    return (code <= 4'd8) ? 8 + int'(code) : 8;
  endfunction

  task automatic load(input logic [15:0] w0, input logic [15:0] w1,
                      input logic [15:0] w2, input int len, input logic lsb);
    logic [15:0] ws [3];
    ws[0] = w0; ws[1] = w1; ws[2] = w2;
    stream = '0;
    for (int w = 0; w < 3; w++)
      for (int k = 0; k < len; k++)
        stream[w*len + k] = ws[w][lsb ? k : len - 1 - k];
    idx = 0;
  endtask

  task automatic pulse_read();
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!rx_done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic power_cycle();
    cfg_on = 1'b0;
    @(negedge clk);
    cfg_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int c, len, cnt_b, cnt_d;
    logic [15:0] expd;

    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 busy", busy, 0);
    check("R13 rx_done", rx_done, 0);
    check("R13 rx_data", rx_data, 0);
    check("R13 overrun", overrun, 0);
    check("R13 sclk idle", sclk, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      cfg_on = 0;
      cfg_lsb_first = VEC[i][31];
      cfg_cpol = VEC[i][30];
      cfg_cpha = VEC[i][29];
      cfg_len = VEC[i][27:24];
      cfg_cont = 0;
      cfg_go = 1;
      cfg_rx_en = 1;
      len = exp_len(VEC[i][27:24]);
      expd = VEC[i][15:0] & 16'((32'd1 << len) - 1);
      load(VEC[i][15:0], 16'h0, 16'h0, len, VEC[i][31]);
      power_cycle();
      check("R5 idle level", sclk, cfg_cpha ^ cfg_cpol);
      pulse_read();
      check("R6 busy after read", busy, 1);
      check("R5 first half level", sclk, cfg_cpol);
      wait_done(c);
      check("R6 word time", c, len * DIV);
      check("R3/R4 word value", rx_data, expd);
      check("R7 busy low at done", busy, 0);
      @(negedge clk);
      check("R7 single pulse", rx_done, 0);
      check("R5 idle after word", sclk, cfg_cpha ^ cfg_cpol);
    end

    // R8: single mode, no further word without a read
    cnt_b = 0; cnt_d = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      cnt_b += int'(busy);
      cnt_d += int'(rx_done);
    end
    check("R8 no auto restart busy", cnt_b, 0);
    check("R8 no auto restart done", cnt_d, 0);

    // R2: rx_en low, then go low
    cfg_rx_en = 0;
    pulse_read();
    cnt_b = 0;
    for (int k = 0; k < 50; k++) begin @(negedge clk); cnt_b += int'(busy); end
    check("R2 rx_en low ignored", cnt_b, 0);
    cfg_rx_en = 1;
    cfg_go = 0;
    pulse_read();
    cnt_b = 0;
    for (int k = 0; k < 50; k++) begin @(negedge clk); cnt_b += int'(busy); end
    check("R2 go low ignored", cnt_b, 0);

    // R9/R10 continuous stream of three words
    cfg_on = 0;
    cfg_lsb_first = 0; cfg_cpol = 0; cfg_cpha = 1; cfg_len = 4'd0;
    cfg_cont = 1; cfg_go = 1; cfg_rx_en = 1;
    load(16'h55, 16'hAA, 16'h0F, 8, 1'b0);
    power_cycle();
    pulse_read();
    wait_done(c);
    check("R9 first word", rx_data, 16'h55);
    @(negedge clk);
    pulse_read();
    check("R9 read while busy keeps running", busy, 1);
    wait_done(c);
    check("R9 back-to-back spacing", c + 2, 8 * DIV);
    check("R9 second word", rx_data, 16'hAA);
    @(negedge clk);
    cfg_go = 0;
    pulse_read();
    wait_done(c);
    check("R10 last word value", rx_data, 16'h0F);
    check("R10 busy low after last", busy, 0);
    cnt_b = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); cnt_b += int'(busy); end
    check("R10 nothing after last", cnt_b, 0);
    check("R11 no overrun when read", overrun, 0);

    // R11 overrun
    cfg_on = 0;
    cfg_go = 1;
    load(16'h12, 16'h34, 16'h0, 8, 1'b0);
    power_cycle();
    pulse_read();
    wait_done(c);
    check("R11 first word no overrun", overrun, 0);
    @(negedge clk);
    cfg_go = 0;
    wait_done(c);
    @(negedge clk);
    check("R11 overrun set", overrun, 1);
    check("R11 newer word kept", rx_data, 16'h34);
    cfg_on = 0;
    @(negedge clk);
    check("R11 cleared by power off", overrun, 0);

    // R1 abort and power-off reads
    cfg_go = 1;
    cfg_cont = 0;
    load(16'hFF, 16'h0, 16'h0, 8, 1'b0);
    cfg_on = 1;
    @(negedge clk);
    pulse_read();
    repeat (10) @(negedge clk);
    cfg_on = 0;
    @(negedge clk);
    check("R1 abort busy", busy, 0);
    check("R1 abort sclk idle", sclk, 1);
    pulse_read();
    cnt_b = 0; cnt_d = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      cnt_b += int'(busy);
      cnt_d += int'(rx_done);
    end
    check("R1 off read ignored", cnt_b, 0);
    check("R1 no completion after abort", cnt_d, 0);
    check("R12 buffer kept", rx_data, 16'h34);

    finish_up();
  end
endmodule